// File: doc/BRIEF.md
# DC Offset Tracker and Remover

This block follows the slow DC component of a signed 14-bit sample stream with a first-order leaky average. On each accepted sample the running estimate moves toward the sample by a fraction of their difference. That fraction is a power of two picked by a 4-bit bandwidth code. Each code step halves the corner frequency, and every code above 13 acts like code 13.

Every accepted sample leaves the block on two output lanes. The signal-path lane carries the sample minus the current estimate when path correction is enabled, and the raw sample otherwise. The monitor lane is controlled the same way by its own enable, so a downstream power or peak monitor can measure with DC removed while the main path stays untouched, or the other way round. The rounded estimate is always visible as a 14-bit value, split into a low byte and a high 6-bit field.

Samples enter on a valid/ready stream. Results leave on a valid/ready stream held in a single register stage. An input is accepted in any cycle where `s_valid` and `s_ready` are both high. `s_ready` is high when the output register is empty or is being drained in that same cycle. While `m_valid` is high and `m_ready` is low, the output register and the estimate hold, and no input is taken.

Top module: `dc_track`

## Requirements
- R1: After reset, `m_valid` is 0 and the DC value (`dc_hi`,`dc_lo`) is 0, because the accumulator is cleared.
- R2: `s_ready` equals `!m_valid || m_ready`. An accepted sample raises `m_valid` on the next cycle. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_path` and `m_mon` hold their values.
- R3: The accumulator is the sample scaled by 2^F, with F = 13 + K0. On each accepted sample x it becomes acc + floor((x·2^F − acc) / 2^k), where k = min(code, 13) + K0. Without an accepted sample it does not change.
- R4: Codes 13, 14 and 15 give exactly the same filter response.
- R5: The DC value is floor((acc + 2^(F−1)) / 2^F), limited to the signed 14-bit range. Bits 7:0 appear on `dc_lo` and bits 13:8 on `dc_hi`.
- R6: With `path_corr_en` high, the `m_path` of an accepted sample is x minus the DC value that was shown before that sample's update. With `path_corr_en` low, `m_path` is x unchanged.
- R7: `m_mon` follows the same rule under `mon_corr_en`, independently of `path_corr_en`.
- R8: A change of `bw_code` does not clear the accumulator. It applies from the next accepted sample on.
- R9: Corrected values are limited to the range −8192 to 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_sample | input | 14 | Signed input sample |
| bw_code | input | 4 | Bandwidth code; each step halves the corner, 13..15 equal |
| path_corr_en | input | 1 | Subtract the estimate on the signal-path lane |
| mon_corr_en | input | 1 | Subtract the estimate on the monitor lane |
| m_valid | output | 1 | Output lanes hold a result |
| m_ready | input | 1 | Downstream takes the result |
| m_path | output | 14 | Signal-path sample, signed |
| m_mon | output | 14 | Monitor-lane sample, signed |
| dc_lo | output | 8 | DC value bits 7:0 |
| dc_hi | output | 6 | DC value bits 13:8 |

## Verification
The bench builds the block with K0 = 1. With that value code 0 moves the estimate half-way on each sample, and code 13 uses a shift of 14. Both the fast settling that drives the estimate to the rails and the slow codes 13 to 15 can then be reached within a few hundred samples. A full-scale step against a settled rail estimate brings out the saturation of the corrected lanes. Random back-pressure and code changes in the middle of a run exercise the hold and continuity rules.

// File: rtl/dc_pkg.sv
package dc_pkg;
  // Highest code with its own bandwidth; larger codes fold onto it.
  localparam int unsigned CODE_CLAMP = 13;
  // Number of output lanes: signal path and monitor.
  localparam int unsigned N_LANES = 2;
  localparam int unsigned LANE_PATH = 0;
  localparam int unsigned LANE_MON  = 1;
endpackage

// File: rtl/dc_shift_sel.sv
module dc_shift_sel
  import dc_pkg::*;
#(
  parameter int unsigned CW = 4,
  parameter int unsigned K0 = 14,
  parameter int unsigned KW = $clog2(CODE_CLAMP + K0 + 1)
) (
  input  logic [CW-1:0] code,
  output logic [KW-1:0] k
);
  localparam logic [CW-1:0] CLAMP_C = CW'(CODE_CLAMP);

  logic [CW-1:0] code_c;

  always_comb begin
    code_c = (code > CLAMP_C) ? CLAMP_C : code;
    k      = KW'(code_c) + KW'(K0);
  end
endmodule

// File: rtl/dc_leaky_acc.sv
module dc_leaky_acc
  import dc_pkg::*;
#(
  parameter int unsigned DW = 14,
  parameter int unsigned K0 = 14,
  parameter int unsigned KW = $clog2(CODE_CLAMP + K0 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] x,
  input  logic [KW-1:0]        k,
  output logic signed [DW-1:0] est
);
  localparam int unsigned FRAC = CODE_CLAMP + K0;
  localparam int unsigned AW   = DW + FRAC + 1;
  localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [AW:0] MAXV = (AW+1)'((2**(DW-1)) - 1);
  localparam logic signed [AW:0] MINV = (AW+1)'(-(2**(DW-1)));

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] xs;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   step;
  logic signed [AW:0]   rnd;
  logic signed [AW:0]   rnd_sh;

  always_comb begin
    xs   = {{(AW-DW-FRAC){x[DW-1]}}, x, {FRAC{1'b0}}};
    diff = {xs[AW-1], xs} - {acc[AW-1], acc};
    step = diff >>> k;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (upd) acc <= acc + step[AW-1:0];
  end

  always_comb begin
    rnd    = {acc[AW-1], acc} + HALF;
    rnd_sh = rnd >>> FRAC;
    if (rnd_sh > MAXV)      est = MAXV[DW-1:0];
    else if (rnd_sh < MINV) est = MINV[DW-1:0];
    else                    est = rnd_sh[DW-1:0];
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(acc)); // R3
endmodule

// File: rtl/dc_subsat.sv
module dc_subsat #(
  parameter int unsigned DW = 14
) (
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] e,
  output logic signed [DW-1:0] y
);
  localparam logic signed [DW:0] MAXV = (DW+1)'((2**(DW-1)) - 1);
  localparam logic signed [DW:0] MINV = (DW+1)'(-(2**(DW-1)));

  logic signed [DW:0] d;

  always_comb begin
    d = {x[DW-1], x} - {e[DW-1], e};
    if (!en)           y = x;
    else if (d > MAXV) y = MAXV[DW-1:0];
    else if (d < MINV) y = MINV[DW-1:0];
    else               y = d[DW-1:0];
  end
endmodule

// File: rtl/dc_track.sv
module dc_track
  import dc_pkg::*;
#(
  parameter int unsigned DW = 14,
  parameter int unsigned CW = 4,
  parameter int unsigned K0 = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_sample,
  input  logic [CW-1:0] bw_code,
  input  logic          path_corr_en,
  input  logic          mon_corr_en,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_path,
  output logic [DW-1:0] m_mon,
  output logic [7:0]    dc_lo,
  output logic [DW-9:0] dc_hi
);
  localparam int unsigned KW = $clog2(CODE_CLAMP + K0 + 1);

  logic                 fire;
  logic [KW-1:0]        k;
  logic signed [DW-1:0] est;
  logic [N_LANES-1:0]   lane_en;
  logic signed [DW-1:0] lane_y [N_LANES];

  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;
  assign lane_en[LANE_PATH] = path_corr_en;
  assign lane_en[LANE_MON]  = mon_corr_en;

  dc_shift_sel #(.CW(CW), .K0(K0), .KW(KW)) u_sel (
    .code (bw_code),
    .k    (k)
  );

  dc_leaky_acc #(.DW(DW), .K0(K0), .KW(KW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (fire),
    .x     (s_sample),
    .k     (k),
    .est   (est)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    dc_subsat #(.DW(DW)) u_sub (
      .en (lane_en[g]),
      .x  (s_sample),
      .e  (est),
      .y  (lane_y[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_path  <= '0;
      m_mon   <= '0;
    end else if (fire) begin
      m_valid <= 1'b1;
      m_path  <= lane_y[LANE_PATH];
      m_mon   <= lane_y[LANE_MON];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assign dc_lo = est[7:0];
  assign dc_hi = est[DW-1:8];

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_path) && $stable(m_mon)); // R2
  AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid); // R2
  AST_PATH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !path_corr_en |=> m_path == $past(s_sample)); // R6
  AST_MON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !mon_corr_en |=> m_mon == $past(s_sample)); // R7
endmodule

// File: tb/sim_dc_track.sv
module sim_dc_track;
  localparam int DW = 14;
  localparam int K0 = 1;
  localparam int F  = 13 + K0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_sample = '0;
  logic [3:0] bw_code = '0;
  logic path_corr_en = 1'b0, mon_corr_en = 1'b0;
  logic s_ready, m_valid;
  logic [DW-1:0] m_path, m_mon;
  logic [7:0] dc_lo;
  logic [5:0] dc_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  longint r_acc = 0;
  bit     r_valid = 1'b0;
  longint r_path = 0, r_mon = 0;

  always #2 clk = ~clk;

  dc_track #(.DW(DW), .CW(4), .K0(K0)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .bw_code(bw_code), .path_corr_en(path_corr_en),
    .mon_corr_en(mon_corr_en), .m_valid(m_valid), .m_ready(m_ready),
    .m_path(m_path), .m_mon(m_mon), .dc_lo(dc_lo), .dc_hi(dc_hi)
  );

  function automatic longint sat14(longint v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic longint ref_dc();
    return sat14((r_acc + (64'sd1 <<< (F-1))) >>> F);
  endfunction

  function automatic longint s14(logic [DW-1:0] v);
    return longint'(signed'(v));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, "/R2 ready"}, longint'(s_ready), longint'(!r_valid || m_ready));
    check({tag, "/R2 valid"}, longint'(m_valid), longint'(r_valid));
    check({tag, "/R5 dc"}, s14({dc_hi, dc_lo}), ref_dc());
    if (r_valid) begin
      check({tag, "/R6 path"}, s14(m_path), r_path);
      check({tag, "/R7 mon"}, s14(m_mon), r_mon);
    end
  endtask

  // one cycle: inputs set at the falling edge, results compared at the next one
  task automatic step(string tag, bit v, longint x, int code, bit pe, bit me, bit rdy);
    longint e, kk;
    bit fire;
    s_valid = v; s_sample = DW'(x); bw_code = 4'(code);
    path_corr_en = pe; mon_corr_en = me; m_ready = rdy;
    fire = v && (!r_valid || rdy);
    e = ref_dc();
    @(posedge clk);
    @(negedge clk);
    if (fire) begin
      kk = ((code > 13) ? 13 : code) + K0;   // R4 clamp
      r_valid = 1'b1;
      r_path = pe ? sat14(x - e) : x;         // R9
      r_mon  = me ? sat14(x - e) : x;
      r_acc  = r_acc + (((x <<< F) - r_acc) >>> kk);  // R3
    end else if (rdy) begin
      r_valid = 1'b0;
    end
    compare_all(tag);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", longint'(m_valid), 0);
    check("R1 dc", s14({dc_hi, dc_lo}), 0);

    // R3 R5 R6: step response on fast code, path corrected
    for (int i = 0; i < 20; i++) step("R3 step", 1, 3000, 0, 1, 0, 1);
    // R7: monitor corrected only
    for (int i = 0; i < 20; i++) step("R7 mon", 1, -1500 + i * 7, 2, 0, 1, 1);
    // R2: random back-pressure and valid
    for (int i = 0; i < 400; i++)
      step("R2 bp", bit'($urandom_range(0, 1)), longint'($urandom_range(0, 16383)) - 8192,
           int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    // R2: long stall, output must hold
    step("R2 load", 1, 1234, 3, 1, 1, 1);
    for (int i = 0; i < 10; i++) step("R2 hold", 1, -4000, 3, 1, 1, 0);
    step("R2 drain", 0, 0, 3, 1, 1, 1);

    // R4: slow codes 13, 14, 15 from a nonzero accumulator
    for (int c = 13; c <= 15; c++)
      for (int i = 0; i < 40; i++) step("R4 slow", 1, 8000, c, 1, 1, 1);

    // R8: code changes mid-run, accumulator keeps its value
    for (int i = 0; i < 30; i++) step("R8 code", 1, -6000, i % 6, 1, 0, 1);
    step("R8 idle", 0, 0, 9, 1, 0, 1);
    step("R8 next", 1, 500, 9, 1, 0, 1);

    // R9: estimate to the negative rail, then full-scale positive input
    for (int i = 0; i < 60; i++) step("R9 settle", 1, -8192, 0, 1, 1, 1);
    step("R9 hi", 1, 8191, 0, 1, 1, 1);
    check("R9 path max", s14(m_path), 8191);
    for (int i = 0; i < 60; i++) step("R9 settle2", 1, 8191, 0, 1, 1, 1);
    step("R9 lo", 1, -8192, 0, 1, 1, 1);
    check("R9 mon min", s14(m_mon), -8192);
    step("R6 off", 1, -8192, 0, 0, 0, 1);
    check("R6 raw", s14(m_path), -8192);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule